// File: doc/BRIEF.md
# Warp-Granular Barrier Synchronizer

This unit holds back the warps of one thread block at a barrier until every warp that takes part has reached it. A warp reports that it has reached the barrier with a single-cycle arrive pulse that carries its warp number. The pulse does not say which lanes were active. A warp whose lanes have split onto different paths therefore satisfies the barrier as a whole when any one of its paths issues the barrier instruction. The unit keeps one arrival bit per warp and raises that warp's stall bit until the barrier opens.

The set of taking-part warps comes from a participation mask. When every warp in the mask has arrived, all stall bits drop together on the next clock edge and a release pulse is raised for one cycle. The arrival state clears at the same edge, so the next barrier can start at once.

An arrival that lands in the same cycle as a release counts toward the next barrier. This lets two barrier instructions that a warp issues back to back pair one-to-one with the two barrier instructions of another warp, even when those sit on different divergent paths. A second arrival from a warp that is already waiting is reported as an error and is otherwise dropped.

Top module: `warp_barrier`

## Requirements
- R1: After reset, `stall`, `release_pulse` and `dup_err` are all zero.
- R2: An arrive pulse from a warp whose `part_mask` bit is 1 sets bit `arrive_wid` of `stall` from the next cycle on, and that bit stays set until a release.
- R3: When the last missing participating warp's arrival is registered (its stall bit goes high at edge e), `release_pulse` is 1 and every `stall` bit is 0 after edge e+1.
- R4: `release_pulse` lasts exactly one cycle unless a new barrier completes immediately. Without an arrival in the releasing cycle, `stall` is all zeros in the release cycle.
- R5: An arrive from a warp whose stall bit is already set, in a cycle with no release pending, raises `dup_err` for exactly the next cycle. It leaves `stall` unchanged and causes no release.
- R6: An arrive from a warp whose `part_mask` bit is 0 is ignored: no stall bit is set, no error is raised and no release is caused.
- R7: An arrive that is presented in the cycle in which all participating warps have arrived is counted toward the next barrier. After the releasing edge, that warp's stall bit is 1 and `dup_err` stays 0.
- R8: With `part_mask` all zeros the unit never releases, and arrivals have no effect.
- R9: An arrive whose `arrive_wid` is not below `NW` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| part_mask | input | NW | 1 for each warp that takes part in the barrier |
| arrive_vld | input | 1 | One-cycle barrier-arrive pulse |
| arrive_wid | input | WW | Warp number of the arriving warp |
| stall | output | NW | 1 for each warp waiting at the barrier |
| release_pulse | output | 1 | One-cycle pulse when the barrier opens |
| dup_err | output | 1 | One-cycle flag for a repeated arrival before release |

## Verification
The bench builds the unit with six warps and a three-bit warp number. The warp count is not a power of two, so the codes 6 and 7 can be driven to exercise the out-of-range rule. Six warps also keep the full-block case short while still allowing partial masks with gaps, such as warps 0, 1 and 3. A two-warp mask makes back-to-back barriers reachable within a few cycles, including an arrival timed exactly on the releasing cycle.

// File: rtl/warp_barrier.sv
module warp_barrier #(
  parameter int NW = 8,
  parameter int WW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] part_mask,
  input  logic          arrive_vld,
  input  logic [WW-1:0] arrive_wid,
  output logic [NW-1:0] stall,
  output logic          release_pulse,
  output logic          dup_err
);

  logic [NW-1:0] arr_q;
  logic [NW-1:0] hit;
  logic          in_range;
  logic          full;
  logic          rel_q;
  logic          err_q;

  assign in_range = arrive_vld && (int'(arrive_wid) < NW);
  assign hit      = in_range ? (({{(NW-1){1'b0}}, 1'b1} << arrive_wid) & part_mask) : '0;
  assign full     = (|part_mask) && ((part_mask & ~arr_q) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arr_q <= '0;
      rel_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      rel_q <= full;
      err_q <= !full && (|(hit & arr_q));
      arr_q <= full ? hit : (arr_q | hit);
    end
  end

  assign stall         = arr_q;
  assign release_pulse = rel_q;
  assign dup_err       = err_q;

  // R2
  stall_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stall & ~$past(stall))) |-> $past(arrive_vld));

  // R3
  rel_when_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(release_pulse) |-> ($past(stall) == $past(part_mask)) && (|$past(part_mask)));

  // R4
  rel_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (release_pulse && !$past(arrive_vld)) |-> (stall == '0));

  // R5
  err_no_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dup_err |-> !release_pulse && $past(arrive_vld) && $stable(stall));

endmodule

// File: tb/test_warp_barrier.sv
`timescale 1ns/1ps
module test_warp_barrier;
  localparam int NW = 6;
  localparam int WW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NW-1:0] part_mask = '0;
  logic          arrive_vld = 1'b0;
  logic [WW-1:0] arrive_wid = '0;
  logic [NW-1:0] stall;
  logic          release_pulse;
  logic          dup_err;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  warp_barrier #(.NW(NW), .WW(WW)) i_warp_barrier (
    .clk(clk), .rst_n(rst_n), .part_mask(part_mask),
    .arrive_vld(arrive_vld), .arrive_wid(arrive_wid),
    .stall(stall), .release_pulse(release_pulse), .dup_err(dup_err)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic arrive(input int w);
    arrive_vld = 1'b1;
    arrive_wid = WW'(w);
    @(negedge clk);
    arrive_vld = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 stall", int'(stall), 0);
    check("R1 release", int'(release_pulse), 0);
    check("R1 err", int'(dup_err), 0);
  endtask

  task automatic t_full_block();
    part_mask = 6'h3F;
    for (int w = 0; w < NW; w++) begin
      arrive(w);
      check("R2 stall accumulate", int'(stall), (1 << (w + 1)) - 1);
      check("R2 no early release", int'(release_pulse), 0);
    end
    idle();
    check("R3 release", int'(release_pulse), 1);
    check("R3 stall cleared", int'(stall), 0);
    idle();
    check("R4 pulse one cycle", int'(release_pulse), 0);
  endtask

  task automatic t_partial_dup();
    part_mask = 6'b001011;
    arrive(3);
    check("R2 warp3", int'(stall), 'b1000);
    arrive(4);
    check("R6 nonpart stall", int'(stall), 'b1000);
    check("R6 nonpart err", int'(dup_err), 0);
    arrive(1);
    check("R2 warp1", int'(stall), 'b1010);
    arrive(3);
    check("R5 dup err", int'(dup_err), 1);
    check("R5 stall unchanged", int'(stall), 'b1010);
    check("R5 no release", int'(release_pulse), 0);
    idle();
    check("R5 err one cycle", int'(dup_err), 0);
    arrive(0);
    check("R2 warp0", int'(stall), 'b1011);
    idle();
    check("R3 partial release", int'(release_pulse), 1);
    check("R3 partial cleared", int'(stall), 0);
    idle();
  endtask

  task automatic t_back_to_back();
    part_mask = 6'b000011;
    arrive(0);
    arrive(1);
    check("R2 both waiting", int'(stall), 'b11);
    arrive(0);
    check("R7 release", int'(release_pulse), 1);
    check("R7 carried arrival", int'(stall), 'b01);
    check("R7 no err", int'(dup_err), 0);
    arrive(1);
    check("R7 second barrier", int'(stall), 'b11);
    check("R4 no repeat release", int'(release_pulse), 0);
    idle();
    check("R3 second release", int'(release_pulse), 1);
    check("R3 second cleared", int'(stall), 0);
    idle();
  endtask

  task automatic t_out_of_range();
    part_mask = 6'h3F;
    arrive(6);
    arrive(7);
    check("R9 stall", int'(stall), 0);
    check("R9 err", int'(dup_err), 0);
    idle();
    check("R9 release", int'(release_pulse), 0);
  endtask

  task automatic t_empty_mask();
    part_mask = '0;
    arrive(2);
    check("R8 stall", int'(stall), 0);
    idle();
    check("R8 release", int'(release_pulse), 0);
    idle();
    check("R8 release later", int'(release_pulse), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_block();
    t_partial_dup();
    t_back_to_back();
    t_out_of_range();
    t_empty_mask();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule